// File: doc/BRIEF.md
# Channel Overcurrent Fault Manager

This block supervises a bank of switched output channels. Each channel has a digital overcurrent sense bit. A sense bit must stay high for a set number of system clock cycles before it counts as a real fault, so short current spikes do not trip the channel. A qualified fault turns off only that channel, and the channel stays off until the enable/reset input is pulsed high or the block is reset. Two global conditions act on all channels. Over-temperature turns every channel off and pulls the error flag low, then releases by itself when it clears. Undervoltage turns every channel off and wipes all latched faults.

The enable/reset input has two roles. While it is high, all outputs are disabled. Its falling edge clears every latched channel fault. The per-channel allow mask is meant to gate the output drivers. The active-low flag reports any latched fault or an active over-temperature condition. The global disable output is high whenever no channel may conduct.

Top module: `ovc_fault_mgr`

## Requirements
- R1: After reset, with all condition inputs low, `chan_allow` is all ones, `fault_n` is 1 and `all_off` is 0.
- R2: A sense bit sampled high on QUAL_CYCLES consecutive rising clock edges latches a fault on that channel at the last of those edges. The latched channel's bit in `chan_allow` (bit i for `oc_sense[i]`) then reads 0, and the other bits are unchanged.
- R3: A sense bit that is high on QUAL_CYCLES-1 consecutive edges and then low on one edge restarts its count, so repeated short pulses never latch a fault.
- R4: `fault_n` is 0 whenever any channel fault is latched or `over_temp` is high. Otherwise it is 1.
- R5: A latched fault persists after its sense bit goes low. It is cleared at the first rising edge that samples `enable_reset` low after having sampled it high.
- R6: While `enable_reset` is high, `chan_allow` is all zeros and `all_off` is 1, and latched faults are kept.
- R7: After a fault is cleared by a reset pulse, a sense bit that is still high must again be held for QUAL_CYCLES full edges before the channel latches again.
- R8: While `over_temp` is high, `chan_allow` is all zeros and `all_off` is 1, and no fault qualifies. When it drops, the channels return with no reset pulse.
- R9: While `under_volt` is high, `chan_allow` is all zeros and `all_off` is 1, and every latched fault is cleared at the next rising edge.
- R10: Channels qualify independently. Staggered faults on two channels each trip at their own time, and neither affects the other's bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset (power cycle) |
| oc_sense | input | CHANNELS | Per-channel overcurrent sense, high = overcurrent |
| over_temp | input | 1 | Over-temperature condition, high = hot |
| under_volt | input | 1 | Undervoltage condition, high = supply too low |
| enable_reset | input | 1 | High disables outputs; falling edge clears latched faults |
| chan_allow | output | CHANNELS | Per-channel drive permission, 1 = channel may conduct |
| fault_n | output | 1 | Active-low error flag |
| all_off | output | 1 | High when every channel is forced off globally |

## Verification
Some properties are checked on every cycle. The qualification counter never passes its limit. A latch can rise only after a full run of high samples. A latch holds unless a clear or a wipe occurs. Undervoltage empties every latch by the next edge. A reset-pulse clear always follows a sampled high level. The flag follows the latch state. Other behaviour only the bench's scenarios can show: the exact trip cycle, that a pulse one cycle short is rejected, the full requalification after a reset pulse, the self-release after over-temperature, and the independence of staggered channels.

// File: rtl/ovc_pkg.sv
package ovc_pkg;
    localparam int unsigned OVC_CHANNELS    = 8;
    localparam int unsigned OVC_QUAL_CYCLES = 250;  // 2 us at 125 MHz
endpackage

// File: rtl/ovc_release_edge.sv
module ovc_release_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic enable_reset,
    output logic release_pulse
);
    typedef struct packed {
        logic seen_high;
    } edge_state_t;

    edge_state_t st_d, st_q;

    always_comb begin
        st_d.seen_high = enable_reset;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign release_pulse = st_q.seen_high && !enable_reset;

    // R5: a clear pulse is only ever produced after a high level was sampled
    a_r5_clear_follows_high: assert property (@(posedge clk) disable iff (!rst_n)
        release_pulse |-> $past(enable_reset));
endmodule

// File: rtl/ovc_chan.sv
module ovc_chan #(
    parameter int unsigned QUAL_CYCLES = ovc_pkg::OVC_QUAL_CYCLES
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sense,
    input  logic freeze,
    input  logic release_pulse,
    input  logic wipe,
    output logic tripped
);
    localparam int unsigned CNT_W = (QUAL_CYCLES < 2) ? 1 : $clog2(QUAL_CYCLES);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(QUAL_CYCLES - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             latch;
    } chan_state_t;

    chan_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wipe || release_pulse) begin
            st_d.cnt   = '0;
            st_d.latch = 1'b0;
        end else if (freeze || st_q.latch || !sense) begin
            st_d.cnt = '0;
        end else if (st_q.cnt == LAST) begin
            st_d.cnt   = '0;
            st_d.latch = 1'b1;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tripped = st_q.latch;

    // R2: the count stays inside the qualification window
    a_r2_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= LAST);

    // R3: a latch rises only from a full count with sense still high
    a_r3_full_run_needed: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.latch) |-> ($past(st_q.cnt) == LAST) && $past(sense));

    // R5: a latch holds unless cleared by a reset pulse or undervoltage
    a_r5_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.latch && !release_pulse && !wipe) |=> st_q.latch);
endmodule

// File: rtl/ovc_fault_mgr.sv
module ovc_fault_mgr #(
    parameter int unsigned CHANNELS    = ovc_pkg::OVC_CHANNELS,
    parameter int unsigned QUAL_CYCLES = ovc_pkg::OVC_QUAL_CYCLES
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [CHANNELS-1:0] oc_sense,
    input  logic                over_temp,
    input  logic                under_volt,
    input  logic                enable_reset,
    output logic [CHANNELS-1:0] chan_allow,
    output logic                fault_n,
    output logic                all_off
);
    logic                release_pulse;
    logic                freeze;
    logic [CHANNELS-1:0] tripped;

    ovc_release_edge u_edge (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable_reset (enable_reset),
        .release_pulse(release_pulse)
    );

    assign freeze = enable_reset || over_temp;

    for (genvar g = 0; g < CHANNELS; g++) begin : g_chan
        ovc_chan #(.QUAL_CYCLES(QUAL_CYCLES)) u_chan (
            .clk          (clk),
            .rst_n        (rst_n),
            .sense        (oc_sense[g]),
            .freeze       (freeze),
            .release_pulse(release_pulse),
            .wipe         (under_volt),
            .tripped      (tripped[g])
        );
    end

    always_comb begin
        all_off    = enable_reset || over_temp || under_volt;
        chan_allow = all_off ? '0 : ~tripped;
        fault_n    = !((|tripped) || over_temp);
    end

    // R9: undervoltage empties every latch by the next edge
    a_r9_uv_wipes: assert property (@(posedge clk) disable iff (!rst_n)
        under_volt |=> (tripped == '0));

    // R8: no channel can newly trip while hot
    a_r8_no_trip_when_hot: assert property (@(posedge clk) disable iff (!rst_n)
        (over_temp && !enable_reset) |=> ($countones(tripped) <= $countones($past(tripped))));

    // R4: the flag is low while any channel latch is set
    a_r4_flag_low_on_latch: assert property (@(posedge clk) disable iff (!rst_n)
        (|tripped) |-> !fault_n);
endmodule

// File: tb/ovc_fault_mgr_test.sv
module ovc_fault_mgr_test;
    localparam int unsigned CH   = 8;
    localparam int unsigned QUAL = 250;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [CH-1:0] oc_sense = '0;
    logic          over_temp = 1'b0;
    logic          under_volt = 1'b0;
    logic          enable_reset = 1'b0;
    logic [CH-1:0] chan_allow;
    logic          fault_n;
    logic          all_off;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    ovc_fault_mgr #(.CHANNELS(CH), .QUAL_CYCLES(QUAL)) uut (
        .clk(clk), .rst_n(rst_n), .oc_sense(oc_sense), .over_temp(over_temp),
        .under_volt(under_volt), .enable_reset(enable_reset),
        .chan_allow(chan_allow), .fault_n(fault_n), .all_off(all_off)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic restart();
        @(negedge clk);
        rst_n = 1'b0;
        oc_sense = '0; over_temp = 1'b0; under_volt = 1'b0; enable_reset = 1'b0;
        edges(2);
        rst_n = 1'b1;
        edges(1);
    endtask

    task automatic pulse_reset();
        enable_reset = 1'b1;
        edges(1);
        enable_reset = 1'b0;
        edges(1);
    endtask

    task automatic t_reset_state();
        restart();
        check("R1 allow", chan_allow, 8'hFF);
        check("R1 flag", fault_n, 1);
        check("R1 all_off", all_off, 0);
    endtask

    task automatic t_trip_exact();
        restart();
        oc_sense = 8'h10;
        edges(QUAL - 1);
        check("R2 before trip", chan_allow, 8'hFF);
        edges(1);
        check("R2 trip ch4", chan_allow, 8'hEF);
        check("R4 flag on trip", fault_n, 0);
    endtask

    task automatic t_short_pulses();
        restart();
        for (int k = 0; k < 3; k++) begin
            oc_sense = 8'h01;
            edges(QUAL - 1);
            oc_sense = 8'h00;
            edges(1);
        end
        check("R3 short pulses ignored", chan_allow, 8'hFF);
        check("R3 flag high", fault_n, 1);
    endtask

    task automatic t_latch_and_clear();
        restart();
        oc_sense = 8'h80;
        edges(QUAL);
        oc_sense = 8'h00;
        edges(20);
        check("R5 latch persists", chan_allow, 8'h7F);
        check("R5 flag held", fault_n, 0);
        enable_reset = 1'b1;
        edges(3);
        check("R6 allow off", chan_allow, 8'h00);
        check("R6 all_off", all_off, 1);
        check("R6 latch kept", fault_n, 0);
        enable_reset = 1'b0;
        #1;
        check("R6 latch visible after release", chan_allow, 8'h7F);
        edges(1);
        check("R5 cleared on falling edge", chan_allow, 8'hFF);
        check("R4 flag restored", fault_n, 1);
    endtask

    task automatic t_requalify();
        restart();
        oc_sense = 8'h02;
        edges(QUAL);
        check("R7 first trip", chan_allow, 8'hFD);
        pulse_reset();
        check("R7 cleared", chan_allow, 8'hFF);
        edges(QUAL - 1);
        check("R7 not yet requalified", chan_allow, 8'hFF);
        edges(1);
        check("R7 requalified", chan_allow, 8'hFD);
    endtask

    task automatic t_hot();
        restart();
        over_temp = 1'b1;
        oc_sense  = 8'h01;
        edges(2 * QUAL);
        check("R8 allow off", chan_allow, 8'h00);
        check("R8 all_off", all_off, 1);
        check("R4 flag hot", fault_n, 0);
        over_temp = 1'b0;
        oc_sense  = 8'h00;
        edges(1);
        check("R8 self release", chan_allow, 8'hFF);
        check("R8 no latch formed", fault_n, 1);
    endtask

    task automatic t_undervolt();
        restart();
        oc_sense = 8'h08;
        edges(QUAL);
        oc_sense = 8'h00;
        check("R9 pre trip", chan_allow, 8'hF7);
        under_volt = 1'b1;
        #1;
        check("R9 allow off", chan_allow, 8'h00);
        check("R9 all_off", all_off, 1);
        edges(1);
        check("R9 latch wiped", fault_n, 1);
        under_volt = 1'b0;
        #1;
        check("R9 all on after", chan_allow, 8'hFF);
    endtask

    task automatic t_independent();
        restart();
        oc_sense = 8'h04;
        edges(100);
        oc_sense = 8'h24;
        edges(QUAL - 100);
        check("R10 ch2 only", chan_allow, 8'hFB);
        edges(99);
        check("R10 ch5 pending", chan_allow, 8'hFB);
        edges(1);
        check("R10 ch5 trips", chan_allow, 8'hDB);
    endtask

    initial begin
        t_reset_state();
        t_trip_exact();
        t_short_pulses();
        t_latch_and_clear();
        t_requalify();
        t_hot();
        t_undervolt();
        t_independent();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule